// File: doc/BRIEF.md
# Timer Capture Input Conditioner

This block is a free-running up-counter paired with one external capture input and two capture/compare channels. The raw pin first crosses into the system clock domain through two flip-flops. It is then sampled on a programmable strobe, and the filter treats a new level as real only after two consecutive samples agree on it. Each accepted transition becomes a rising or falling edge event. These events drive the two channels, and in one mode they drive the counter itself.

The count clock arrives as a level signal that is synchronous to the system clock. On its rising half the counter advances. On its falling half a pending capture copies the counter value into the channel register. The channel's interrupt pulse follows at the next rising half. A channel placed in compare mode holds a software-written value and pulses a match output when the counter reaches that value, and it ignores capture triggers. The edge history starts low after reset and keeps tracking the pin once the block has run at least once. As a result, a pin that is already high at the first start reports a rising edge, while a restart with the pin high reports nothing.

Top module: `tcap_unit`

## Requirements
- R1: After reset the counter, both channel registers, both interrupt outputs and both match outputs are zero.
- R2: A 0-to-1 change of `run` clears the counter to 0. While `run` is high and pin counting is off, each rising half of `tick_clk` adds one, wrapping from all-ones to zero. While `run` is low the counter holds.
- R3: The filter samples the synchronized pin once every 2^`cfg_fdiv` system clocks. A new level is accepted only when two consecutive samples both show it, so a pulse seen by a single sample produces no edge.
- R4: `cfg_edge` bit 0 selects rising edges and bit 1 selects falling edges (11 selects both, 00 selects none). Channel 0 triggers on the selected edges. Channel 1 triggers on the mirrored selection, with rising and falling swapped.
- R5: A trigger causes a capture at the first falling half of `tick_clk` that follows it. The capture copies the counter value at that moment into the channel register.
- R6: A channel's interrupt is a one-system-clock pulse at the rising half of `tick_clk` that follows its capture, and never before it.
- R7: A channel with its `cfg_cmp` bit set ignores capture triggers. It pulses its `cmp_match` bit when its register equals the counter at a rising half of `tick_clk`.
- R8: With `cfg_pincnt` set, the counter advances once per channel-0 valid pin edge, ignores `tick_clk`, and neither channel captures.
- R9: On the first start after reset, with rising edges selected and the pin already high, a rising edge is reported and captured.
- R10: A restart after a stop, with the pin high and unchanged, reports no edge.
- R11: A configuration write while `run` is high has no effect.
- R12: A `cr_we` bit loads `cr_wdata` into its channel register at the next clock. The write takes precedence over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (high) / stop (low) |
| tick_clk | input | 1 | Count clock level, synchronous to clk |
| cap_pin | input | 1 | External capture input (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_edge | input | 2 | Edge select: bit0 rising, bit1 falling |
| cfg_cmp | input | 2 | Per-channel compare-mode enable |
| cfg_pincnt | input | 1 | Count pin edges instead of tick_clk |
| cfg_fdiv | input | FDIV_W | Filter strobe divide exponent |
| cr_we | input | 2 | Per-channel register write strobe |
| cr_wdata | input | CNT_W | Register write data |
| cnt_val | output | CNT_W | Counter value |
| cr0_val | output | CNT_W | Channel 0 register |
| cr1_val | output | CNT_W | Channel 1 register |
| cap_irq | output | 2 | Per-channel capture interrupt pulse |
| cmp_match | output | 2 | Per-channel compare match pulse |

## Verification
The bench builds the block with CNT_W=8 and FDIV_W=2. The narrow counter makes the wrap from 255 to 0 reachable in 256 count periods. The 2-bit divide select covers filter strobes of 1, 2, 4 and 8 clocks, so the same short pulse can be shown rejected at a slow strobe and accepted at the fastest one. Because it is the first start after reset, the first-start case is exercised with the pin held high from time zero, and the restart case follows directly after it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int NUM_CH = 2;

  // true when an event matches the selection (bit0 rising, bit1 falling)
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

  // swap rising and falling selection
  function automatic logic [1:0] mirror_sel(input logic [1:0] sel);
    return {sel[0], sel[1]};
  endfunction

endpackage

// File: rtl/tcap_filter.sv
module tcap_filter #(
  parameter int FDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  input  logic              run,
  input  logic [FDIV_W-1:0] fdiv,
  output logic              rise_ev,
  output logic              fall_ev
);

  localparam int DCNT_W = (1 << FDIV_W) - 1;

  logic              sync_a, sync_b;
  logic              smp_q, hist_q, armed_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DCNT_W-1:0] mask;
  logic              strobe, tracking, accept;

  // low bits of the divider that must be zero for a sampling strobe
  function automatic logic [DCNT_W-1:0] div_mask(input logic [FDIV_W-1:0] s);
    logic [DCNT_W-1:0] m;
    for (int i = 0; i < DCNT_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  assign mask     = div_mask(fdiv);
  assign strobe   = ((dcnt_q & mask) == '0);
  // history is frozen low until the first start, then always follows the pin
  assign tracking = run | armed_q;
  assign accept   = (sync_b == smp_q) && (sync_b != hist_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      smp_q   <= 1'b0;
      hist_q  <= 1'b0;
      armed_q <= 1'b0;
      dcnt_q  <= '0;
      rise_ev <= 1'b0;
      fall_ev <= 1'b0;
    end else begin
      sync_a  <= pin;
      sync_b  <= sync_a;
      dcnt_q  <= dcnt_q + 1'b1;
      armed_q <= armed_q | run;
      rise_ev <= 1'b0;
      fall_ev <= 1'b0;
      if (strobe && tracking) begin
        smp_q <= sync_b;
        if (accept) begin
          hist_q  <= sync_b;
          rise_ev <= run & sync_b;
          fall_ev <= run & ~sync_b;
        end
      end
    end
  end

  // R3: history only moves to a level seen by two consecutive samples
  a_r3_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q != $past(hist_q)) |-> ($past(smp_q) == hist_q && $past(sync_b) == hist_q));

  // R3: a reported rising edge leaves the history high
  a_r3_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |-> hist_q);

  // R10: no edge is reported for a cycle in which the block was stopped
  a_r10_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(rise_ev || fall_ev));

endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_clk,
  input  logic             pin_mode,
  input  logic             pin_step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic run_q, tick_q, start, step;

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  assign tick_rise = tick_clk & ~tick_q;
  assign tick_fall = ~tick_clk & tick_q;
  assign start     = run & ~run_q;
  assign step      = pin_mode ? pin_step : tick_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run;
      tick_q <= tick_clk;
      if (start)             cnt_q <= '0;
      else if (run && step)  cnt_q <= cnt_inc(cnt_q);
    end
  end

  // R2: counter holds while stopped
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(cnt_q)));

  // R2: start clears the counter
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (cnt_q == '0));

  // R8: in pin mode the count clock alone does not move the counter
  a_r8_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && pin_mode && !pin_step) |=> $stable(cnt_q));

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit MIRROR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pin_mode,
  input  logic             cmp_mode,
  input  logic [1:0]       edge_sel,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             tick_rise,
  input  logic             tick_fall,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cr_q,
  output logic             irq,
  output logic             match
);

  logic [1:0] sel;
  logic       trig, grab, pend_q, ipend_q;

  assign sel  = MIRROR ? mirror_sel(edge_sel) : edge_sel;
  assign trig = edge_hit(sel, rise_ev, fall_ev) & ~cmp_mode & ~pin_mode;
  assign grab = tick_fall & pend_q & ~cmp_mode & ~pin_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q    <= '0;
      pend_q  <= 1'b0;
      ipend_q <= 1'b0;
      irq     <= 1'b0;
      match   <= 1'b0;
    end else begin
      irq   <= 1'b0;
      match <= 1'b0;
      if (!run) begin
        pend_q  <= 1'b0;
        ipend_q <= 1'b0;
      end else begin
        if (grab) pend_q <= 1'b0;
        if (trig) pend_q <= 1'b1;
        if (grab) ipend_q <= 1'b1;
        else if (tick_rise && ipend_q) begin
          ipend_q <= 1'b0;
          irq     <= 1'b1;
        end
        if (tick_rise && cmp_mode && (cnt == cr_q)) match <= 1'b1;
      end
      if (wr_en)             cr_q <= wr_data;
      else if (run && grab)  cr_q <= cnt;
    end
  end

  // R6: interrupt is a single-clock pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: interrupt only follows a count-clock rising half
  a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick_rise));

  // R5: without a write, the register only changes on a falling half
  a_r5_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick_fall) |=> $stable(cr_q));

  // R7: compare mode keeps the register unless software writes it
  a_r7_compare_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && !wr_en) |=> (cr_q == $past(cr_q)));

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick_clk,
  input  logic              cap_pin,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_edge,
  input  logic [1:0]        cfg_cmp,
  input  logic              cfg_pincnt,
  input  logic [FDIV_W-1:0] cfg_fdiv,
  input  logic [1:0]        cr_we,
  input  logic [CNT_W-1:0]  cr_wdata,
  output logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  cr0_val,
  output logic [CNT_W-1:0]  cr1_val,
  output logic [1:0]        cap_irq,
  output logic [1:0]        cmp_match
);

  edge_sel_e         edge_q;
  logic [NUM_CH-1:0] cmp_q;
  logic              pincnt_q;
  logic [FDIV_W-1:0] fdiv_q;

  logic              rise_ev, fall_ev, tick_rise, tick_fall, pin_step;
  logic [CNT_W-1:0]  cr_arr [NUM_CH];

  // configuration is only accepted while stopped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q   <= EDGE_RISE;
      cmp_q    <= '0;
      pincnt_q <= 1'b0;
      fdiv_q   <= '0;
    end else if (cfg_we && !run) begin
      edge_q   <= edge_sel_e'(cfg_edge);
      cmp_q    <= cfg_cmp;
      pincnt_q <= cfg_pincnt;
      fdiv_q   <= cfg_fdiv;
    end
  end

  assign pin_step = pincnt_q & edge_hit(edge_q, rise_ev, fall_ev);

  tcap_filter #(.FDIV_W(FDIV_W)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (cap_pin),
    .run     (run),
    .fdiv    (fdiv_q),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  tcap_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick_clk  (tick_clk),
    .pin_mode  (pincnt_q),
    .pin_step  (pin_step),
    .cnt_q     (cnt_val),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tcap_channel #(.CNT_W(CNT_W), .MIRROR(g == 1)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .pin_mode  (pincnt_q),
      .cmp_mode  (cmp_q[g]),
      .edge_sel  (edge_q),
      .rise_ev   (rise_ev),
      .fall_ev   (fall_ev),
      .tick_rise (tick_rise),
      .tick_fall (tick_fall),
      .cnt       (cnt_val),
      .wr_en     (cr_we[g]),
      .wr_data   (cr_wdata),
      .cr_q      (cr_arr[g]),
      .irq       (cap_irq[g]),
      .match     (cmp_match[g])
    );
  end

  assign cr0_val = cr_arr[0];
  assign cr1_val = cr_arr[1];

  // R11: configuration stays put across a cycle in which run is high
  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(edge_q) && $stable(cmp_q) && $stable(pincnt_q) && $stable(fdiv_q)));

  // R8: pin counting suppresses every capture interrupt
  a_r8_no_irq_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pincnt_q) && pincnt_q) |-> (cap_irq == 2'b00));

endmodule

// File: tb/tcap_unit_test.sv
module tcap_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int H  = 8;
  localparam int CW = 8;
  localparam int FW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          tick_clk = 1'b0;
  logic          cap_pin = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_edge = 2'b01;
  logic [1:0]    cfg_cmp = 2'b00;
  logic          cfg_pincnt = 1'b0;
  logic [FW-1:0] cfg_fdiv = '0;
  logic [1:0]    cr_we = 2'b00;
  logic [CW-1:0] cr_wdata = '0;
  logic [CW-1:0] cnt_val, cr0_val, cr1_val;
  logic [1:0]    cap_irq, cmp_match;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int irq0_n = 0, irq1_n = 0, m1_n = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic          mdl_pincnt = 1'b0;

  tcap_unit #(.CNT_W(CW), .FDIV_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_clk(tick_clk), .cap_pin(cap_pin),
    .cfg_we(cfg_we), .cfg_edge(cfg_edge), .cfg_cmp(cfg_cmp), .cfg_pincnt(cfg_pincnt),
    .cfg_fdiv(cfg_fdiv), .cr_we(cr_we), .cr_wdata(cr_wdata), .cnt_val(cnt_val),
    .cr0_val(cr0_val), .cr1_val(cr1_val), .cap_irq(cap_irq), .cmp_match(cmp_match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cap_irq[0])   irq0_n++;
    if (cap_irq[1])   irq1_n++;
    if (cmp_match[1]) m1_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_cycle();
    tick_clk = 1'b1;
    if (run && !mdl_pincnt) exp_cnt = exp_cnt + 1'b1;
    step(H);
    tick_clk = 1'b0;
    step(H);
  endtask

  task automatic start_run();
    run = 1'b1; exp_cnt = '0; step(1);
  endtask

  task automatic stop_run();
    run = 1'b0; step(2);
  endtask

  task automatic write_cfg(input logic [1:0] e, input logic [1:0] c, input logic p, input logic [FW-1:0] f);
    cfg_edge = e; cfg_cmp = c; cfg_pincnt = p; cfg_fdiv = f; cfg_we = 1'b1;
    if (!run) mdl_pincnt = p;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    cap_pin = v; step(16);
  endtask

  task automatic pulse_pin(input int w);
    cap_pin = ~cap_pin; step(w); cap_pin = ~cap_pin; step(16);
  endtask

  task automatic t_reset();
    chk("R1 counter", int'(cnt_val), 0);
    chk("R1 cr0", int'(cr0_val), 0);
    chk("R1 cr1", int'(cr1_val), 0);
    chk("R1 irq", int'(cap_irq), 0);
    chk("R1 match", int'(cmp_match), 0);
  endtask

  task automatic t_first_start();  // R9
    write_cfg(2'b01, 2'b00, 1'b0, 2'd1);
    start_run(); step(16);
    tick_cycle();
    chk("R9 first-start capture cr0", int'(cr0_val), int'(exp_cnt));
    chk("R6 no irq before rise", irq0_n, 0);
    tick_cycle();
    chk("R9 irq0 after rise", irq0_n, 1);
    chk("R9 cr1 untouched", int'(cr1_val), 0);
  endtask

  task automatic t_restart();  // R10
    stop_run(); step(8);
    start_run(); step(16);
    tick_cycle(); tick_cycle();
    chk("R10 no spurious irq0", irq0_n, 1);
    chk("R10 no spurious irq1", irq1_n, 0);
  endtask

  task automatic t_count();  // R2
    tick_cycle(); tick_cycle(); tick_cycle();
    chk("R2 counts rises", int'(cnt_val), 5);
    stop_run(); tick_cycle();
    chk("R2 holds stopped", int'(cnt_val), 5);
    start_run();
    chk("R2 start clears", int'(cnt_val), 0);
  endtask

  task automatic t_edges();  // R4 R5 R6
    int i0, i1;
    tick_cycle(); tick_cycle();
    i1 = irq1_n;
    set_pin(1'b0); tick_cycle();
    chk("R5 cr1 on falling (mirror)", int'(cr1_val), int'(exp_cnt));
    chk("R6 irq1 waits for rise", irq1_n, i1);
    tick_cycle();
    chk("R6 irq1 one pulse", irq1_n, i1 + 1);
    i0 = irq0_n;
    set_pin(1'b1); tick_cycle();
    chk("R4 cr0 on rising", int'(cr0_val), int'(exp_cnt));
    tick_cycle();
    chk("R6 irq0 one pulse", irq0_n, i0 + 1);
    stop_run(); write_cfg(2'b11, 2'b00, 1'b0, 2'd1); start_run();
    tick_cycle(); set_pin(1'b0); tick_cycle();
    chk("R4 both: cr0", int'(cr0_val), 2);
    chk("R4 both: cr1", int'(cr1_val), 2);
    stop_run(); write_cfg(2'b10, 2'b00, 1'b0, 2'd1); start_run();
    tick_cycle(); tick_cycle();
    i0 = irq0_n;
    set_pin(1'b1); tick_cycle(); tick_cycle();
    chk("R4 falling-only: cr1 mirror", int'(cr1_val), 3);
    chk("R4 falling-only: cr0 kept", int'(cr0_val), 2);
    chk("R4 falling-only: no irq0", irq0_n, i0);
  endtask

  task automatic t_glitch();  // R3
    int i0, i1;
    stop_run(); write_cfg(2'b01, 2'b00, 1'b0, 2'd1);
    set_pin(1'b0); start_run(); tick_cycle();
    i0 = irq0_n;
    pulse_pin(2); tick_cycle(); tick_cycle();
    chk("R3 one-sample glitch ignored", irq0_n, i0);
    stop_run(); write_cfg(2'b01, 2'b00, 1'b0, 2'd2); start_run(); tick_cycle();
    pulse_pin(3); tick_cycle(); tick_cycle();
    chk("R3 slow strobe rejects 3-clk pulse", irq0_n, i0);
    stop_run(); write_cfg(2'b01, 2'b00, 1'b0, 2'd0); start_run(); tick_cycle();
    i1 = irq1_n;
    pulse_pin(3); tick_cycle();
    chk("R3 fast strobe accepts: cr0", int'(cr0_val), 2);
    chk("R3 fast strobe accepts: cr1", int'(cr1_val), 2);
    tick_cycle();
    chk("R3 fast strobe irq0", irq0_n, i0 + 1);
    chk("R3 fast strobe irq1", irq1_n, i1 + 1);
  endtask

  task automatic t_cfg_lock();  // R11
    write_cfg(2'b10, 2'b00, 1'b0, 2'd0);
    set_pin(1'b1); tick_cycle();
    chk("R11 write ignored while running", int'(cr0_val), int'(exp_cnt));
  endtask

  task automatic t_compare();  // R7 R12
    int i1, m0;
    stop_run(); write_cfg(2'b01, 2'b10, 1'b0, 2'd1); start_run();
    cr_wdata = 8'd3; cr_we = 2'b10; step(1); cr_we = 2'b00;
    chk("R12 write loads cr1", int'(cr1_val), 3);
    m0 = m1_n;
    tick_cycle(); tick_cycle(); tick_cycle();
    chk("R7 no match yet", m1_n, m0);
    tick_cycle();
    chk("R7 match at equal count", m1_n, m0 + 1);
    i1 = irq1_n;
    set_pin(1'b0); tick_cycle(); tick_cycle();
    chk("R7 compare blocks capture", int'(cr1_val), 3);
    chk("R7 compare blocks irq", irq1_n, i1);
  endtask

  task automatic t_pincount();  // R8
    int i0;
    logic [CW-1:0] c0;
    stop_run(); write_cfg(2'b01, 2'b00, 1'b1, 2'd1); start_run();
    i0 = irq0_n; c0 = cr0_val;
    for (int k = 0; k < 3; k++) begin
      set_pin(1'b1); set_pin(1'b0);
    end
    chk("R8 counts pin rises", int'(cnt_val), 3);
    tick_cycle(); tick_cycle();
    chk("R8 tick ignored", int'(cnt_val), 3);
    chk("R8 no capture", int'(cr0_val), int'(c0));
    chk("R8 no irq", irq0_n, i0);
  endtask

  task automatic t_wrap();  // R2
    stop_run(); write_cfg(2'b01, 2'b00, 1'b0, 2'd1); start_run();
    for (int k = 0; k < 255; k++) tick_cycle();
    chk("R2 reaches all-ones", int'(cnt_val), 255);
    tick_cycle();
    chk("R2 wraps to zero", int'(cnt_val), int'(exp_cnt));
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_first_start();
    t_restart();
    t_count();
    t_edges();
    t_glitch();
    t_cfg_lock();
    t_compare();
    t_pincount();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule